// File: doc/BRIEF.md
# Single-to-Double Float Widener

This block sits on the load path of a floating-point unit. It takes the four bytes of a 32-bit word as memory returns them, puts them in big-endian order to form an IEEE binary32 pattern, and converts that pattern into the binary64 pattern that fills a 64-bit float register. Every binary32 value has an exact binary64 form, so the block does no rounding and raises no flags. Zeros, normals, subnormals, infinities and both kinds of NaN each follow their own path.

The conversion is a combinational datapath. It is followed by `LAT` register stages, two by default. A valid bit travels with the data through these stages. Each output stage loads only when its valid bit is set. With `LAT` set to 0 the block is purely combinational.

Top module: `fwiden_top`

## Requirements
- R1: `mem_bytes_i[7:0]` holds the byte at the lowest address and becomes bits 31:24 of the binary32 word. `mem_bytes_i[15:8]` becomes bits 23:16, `mem_bytes_i[23:16]` becomes bits 15:8, and `mem_bytes_i[31:24]` becomes bits 7:0.
- R2: After reset, `vld_o` and `res_o` are 0. A result appears on `res_o` with `vld_o` high exactly `LAT` cycles (2 by default) after `vld_i` was sampled high. `vld_o` stays low for cycles in which no input was accepted.
- R3: Bit 63 of `res_o` equals bit 31 of the binary32 word for every input class.
- R4: An input whose exponent and fraction are both zero yields a zero with the same sign: bits 62:0 are all 0.
- R5: For a normal input (exponent 1 to 254), the result exponent (bits 62:52) is the input exponent plus 896. The result fraction (bits 51:0) is the 23-bit input fraction shifted left by 29.
- R6: For a subnormal input (exponent 0, fraction nonzero), let k be the number of leading zeros in the 23-bit fraction. The result exponent is 896 − k. The result fraction holds the fraction bits below its leading one, left-aligned in bits 51:0. The result is never zero.
- R7: An input with exponent 255 and fraction 0 yields exponent 2047 and fraction 0, which is an infinity of the same sign.
- R8: An input with exponent 255 and nonzero fraction yields exponent 2047 with the fraction shifted left by 29. Bit 51 (the quiet bit) therefore equals input bit 22, so a signalling NaN stays signalling.
- R9: While no new result arrives, `res_o` holds the last result delivered.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input bytes are valid this cycle |
| mem_bytes_i | input | 32 | Four bytes from memory; lane 0 (bits 7:0) is the lowest address |
| vld_o | output | 1 | `res_o` carries a new result |
| res_o | output | 64 | Binary64 result |

## Verification
The bench sweeps all 256 exponent codes with both signs. Each exponent is tried with fractions that separate the rebiasing path, the infinity/NaN path and the zero/subnormal path. These fractions also show whether the top fraction bit (the quiet bit) is moved or altered.

Subnormals are tried with the leading one at every one of the 23 positions. Each position is paired with an all-ones tail, and also with an empty tail. Together these pin down the leading-zero count, the exponent offset 896 − k and the left shift. The smallest and largest subnormals are among these cases.

Random words, an isolated load and an idle stretch then test the byte order, the latency count and that the result holds between loads.

// File: rtl/fwid_pkg.sv
package fwid_pkg;
  localparam int unsigned SP_EXP_W = 8;
  localparam int unsigned SP_MAN_W = 23;
  localparam int unsigned DP_EXP_W = 11;
  localparam int unsigned DP_MAN_W = 52;

  typedef enum logic [2:0] {
    FC_ZERO,
    FC_SUB,
    FC_NORM,
    FC_INF,
    FC_NAN
  } fcls_e;
endpackage

// File: rtl/fwid_byte_asm.sv
module fwid_byte_asm #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] bytes_i,
  output logic [W-1:0] word_o
);
  localparam int unsigned NB = W / 8;

  // lane 0 = lowest address = most significant byte
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign word_o[W-1-8*i -: 8] = bytes_i[8*i +: 8];
  end
endmodule

// File: rtl/fwid_lzc.sv
module fwid_lzc #(
  parameter int unsigned W  = 23,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (data_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fwid_conv.sv
module fwid_conv
  import fwid_pkg::*;
#(
  parameter int unsigned SE = SP_EXP_W,
  parameter int unsigned SM = SP_MAN_W,
  parameter int unsigned DE = DP_EXP_W,
  parameter int unsigned DM = DP_MAN_W
) (
  input  logic [SE+SM:0] sp_i,
  output logic [DE+DM:0] dp_o
);
  localparam int unsigned BIAS_D = (1 << (DE - 1)) - (1 << (SE - 1));
  localparam int unsigned CW     = $clog2(SM + 1);
  localparam int unsigned PAD    = DM - SM;

  logic          sgn;
  logic [SE-1:0] e_in;
  logic [SM-1:0] m_in;
  assign {sgn, e_in, m_in} = sp_i;

  logic [CW-1:0] lz;
  fwid_lzc #(.W(SM), .CW(CW)) u_lzc (
    .data_i (m_in),
    .cnt_o  (lz)
  );

  fcls_e cls;
  always_comb begin
    if (e_in == '0)      cls = (m_in == '0) ? FC_ZERO : FC_SUB;
    else if (&e_in)      cls = (m_in == '0) ? FC_INF  : FC_NAN;
    else                 cls = FC_NORM;
  end

  // drop leading one of subnormal fraction
  logic [SM-1:0] m_norm;
  assign m_norm = m_in << (lz + CW'(1));

  logic [DE-1:0] e_out;
  logic [DM-1:0] m_out;
  always_comb begin
    e_out = '0;
    m_out = '0;
    case (cls)
      FC_ZERO: begin
        e_out = '0;
        m_out = '0;
      end
      FC_SUB: begin
        e_out = DE'(BIAS_D) - DE'(lz);
        m_out = {m_norm, {PAD{1'b0}}};
      end
      FC_NORM: begin
        e_out = DE'(e_in) + DE'(BIAS_D);
        m_out = {m_in, {PAD{1'b0}}};
      end
      default: begin // FC_INF, FC_NAN: payload and quiet bit untouched
        e_out = '1;
        m_out = {m_in, {PAD{1'b0}}};
      end
    endcase
  end

  assign dp_o = {sgn, e_out, m_out};
endmodule

// File: rtl/fwid_pipe.sv
module fwid_pipe #(
  parameter int unsigned W   = 64,
  parameter int unsigned LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  if (LAT == 0) begin : g_comb
    assign vld_o  = vld_i;
    assign data_o = data_i;
  end else begin : g_reg
    logic [LAT-1:0] vld_q;
    logic [W-1:0]   data_q [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
      logic         v_in;
      logic [W-1:0] d_in;
      if (s == 0) begin : g_first
        assign v_in = vld_i;
        assign d_in = data_i;
      end else begin : g_next
        assign v_in = vld_q[s-1];
        assign d_in = data_q[s-1];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[s]  <= 1'b0;
          data_q[s] <= '0;
        end else begin
          vld_q[s] <= v_in;
          if (v_in) data_q[s] <= d_in;
        end
      end
    end

    assign vld_o  = vld_q[LAT-1];
    assign data_o = data_q[LAT-1];
  end
endmodule

// File: rtl/fwiden_top.sv
module fwiden_top
  import fwid_pkg::*;
#(
  parameter int unsigned SE  = SP_EXP_W,
  parameter int unsigned SM  = SP_MAN_W,
  parameter int unsigned DE  = DP_EXP_W,
  parameter int unsigned DM  = DP_MAN_W,
  parameter int unsigned LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [SE+SM:0]   mem_bytes_i,
  output logic             vld_o,
  output logic [DE+DM:0]   res_o
);
  localparam int unsigned IN_W   = 1 + SE + SM;
  localparam int unsigned OUT_W  = 1 + DE + DM;
  localparam int unsigned BIAS_D = (1 << (DE - 1)) - (1 << (SE - 1));

  logic [IN_W-1:0]  sp_word;
  logic [OUT_W-1:0] dp_word;

  fwid_byte_asm #(.W(IN_W)) u_asm (
    .bytes_i (mem_bytes_i),
    .word_o  (sp_word)
  );

  fwid_conv #(.SE(SE), .SM(SM), .DE(DE), .DM(DM)) u_conv (
    .sp_i (sp_word),
    .dp_o (dp_word)
  );

  fwid_pipe #(.W(OUT_W), .LAT(LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_i),
    .data_i (dp_word),
    .vld_o  (vld_o),
    .data_o (res_o)
  );

  logic [SE-1:0] a_e;
  logic [SM-1:0] a_m;
  logic [DE-1:0] a_de;
  logic [DM-1:0] a_dm;
  assign a_e  = sp_word[IN_W-2 -: SE];
  assign a_m  = sp_word[SM-1:0];
  assign a_de = dp_word[OUT_W-2 -: DE];
  assign a_dm = dp_word[DM-1:0];

  // sign comes from top bit of lowest-address byte
  p_sign_lane0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> dp_word[OUT_W-1] == mem_bytes_i[7]);

  p_zero_signed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && a_e == '0 && a_m == '0) |-> dp_word[OUT_W-2:0] == '0);

  p_sub_normal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && a_e == '0 && a_m != '0) |->
      (a_de != '0 && a_de <= DE'(BIAS_D)));

  p_inf_exp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (&a_e) && a_m == '0) |-> ((&a_de) && a_dm == '0));

  p_snan_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (&a_e) && a_m != '0 && !a_m[SM-1]) |->
      ((&a_de) && !a_dm[DM-1] && a_dm != '0));

  p_norm_exp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && a_e != '0 && !(&a_e)) |-> a_de > DE'(BIAS_D));
endmodule

// File: tb/test_fwiden_top.sv
`timescale 1ns/1ps
module test_fwiden_top;
  logic        clk;
  logic        rst_n;
  logic        vld_i;
  logic [31:0] mem_bytes;
  logic        vld_o;
  logic [63:0] res_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [63:0] exp_q [$];
  logic [31:0] in_q  [$];

  fwiden_top i_fwiden_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vld_i       (vld_i),
    .mem_bytes_i (mem_bytes),
    .vld_o       (vld_o),
    .res_o       (res_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [63:0] ref_conv(input logic [31:0] w);
    logic [7:0]  e;
    logic [23:0] m;
    logic [10:0] de;
    logic [51:0] df;
    int          sh;
    e = w[30:23];
    m = {1'b0, w[22:0]};
    if (e == 8'hff) begin
      de = 11'h7ff; df = {w[22:0], 29'b0};
    end else if (e == 0 && m == 0) begin
      de = 0; df = 0;
    end else if (e == 0) begin
      sh = 0;
      while (!m[23]) begin m = m << 1; sh++; end
      de = 11'(897 - sh); df = {m[22:0], 29'b0};
    end else begin
      de = 11'(int'(e) - 127 + 1023); df = {w[22:0], 29'b0};
    end
    return {w[31], de, df};
  endfunction

  function automatic string req_of(input logic [31:0] w);
    if (w[30:23] == 8'hff) return (w[22:0] == 0) ? "R7" : "R8";
    if (w[30:23] == 0)     return (w[22:0] == 0) ? "R4" : "R6";
    return "R5";
  endfunction

  // R1: lane 0 carries bits 31:24
  function automatic logic [31:0] to_lanes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  task automatic sample_out();
    logic [63:0] e;
    logic [31:0] w;
    if (vld_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2", 64'(vld_o), 64'd0);
      end else begin
        e = exp_q.pop_front();
        w = in_q.pop_front();
        chk(res_o == e, req_of(w), res_o, e);
        chk(res_o[63] == w[31], "R3", 64'(res_o[63]), 64'(w[31]));
      end
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w);
    sample_out();
    vld_i     = v;
    mem_bytes = to_lanes(w);
    if (v) begin
      exp_q.push_back(ref_conv(w));
      in_q.push_back(w);
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  localparam logic [22:0] MANS [8] = '{23'h0, 23'h1, 23'h400000, 23'h3fffff,
                                       23'h7fffff, 23'h200000, 23'h155555, 23'h2aaaaa};

  initial begin
    logic [63:0] last;
    rst_n = 0; vld_i = 0; mem_bytes = '0;
    repeat (3) @(negedge clk);
    chk(vld_o == 0 && res_o == 0, "R2", res_o, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // isolated load: latency of 2
    vld_i = 1; mem_bytes = to_lanes(32'h3f800000);
    @(negedge clk);
    vld_i = 0; mem_bytes = to_lanes(32'hdeadbeef);
    chk(vld_o == 0, "R2", 64'(vld_o), 64'd0);
    @(negedge clk);
    chk(vld_o == 1, "R2", 64'(vld_o), 64'd1);
    chk(res_o == 64'h3ff0000000000000, "R5", res_o, 64'h3ff0000000000000);
    @(negedge clk);
    chk(vld_o == 0, "R2", 64'(vld_o), 64'd0);
    repeat (5) @(negedge clk);
    chk(res_o == 64'h3ff0000000000000, "R9", res_o, 64'h3ff0000000000000);

    // byte order: asymmetric lanes
    step(1, 32'h40490fdb);
    step(1, 32'hc0000001);

    // exponent sweep
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++)
        for (int k = 0; k < 8; k++)
          step(1, {1'(s), 8'(e), MANS[k]});

    // subnormals: leading one at each position
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 23; i++) begin
        step(1, {1'(s), 8'h00, 23'(1 << i)});
        step(1, {1'(s), 8'h00, 23'((1 << (i + 1)) - 1)});
      end

    // named corners
    step(1, 32'h00000000); step(1, 32'h80000000);
    step(1, 32'h00000001); step(1, 32'h007fffff);
    step(1, 32'h7f7fffff); step(1, 32'h7f800000);
    step(1, 32'hff800000); step(1, 32'h7fc00000);
    step(1, 32'h7f800001); step(1, 32'hffa00000);

    // random, with gaps
    for (int n = 0; n < 20000; n++)
      step(($urandom % 4) != 0, $urandom);

    for (int n = 0; n < 4; n++) step(0, 32'h0);
    chk(exp_q.size() == 0, "R2", 64'(exp_q.size()), 64'd0);

    last = res_o;
    for (int n = 0; n < 6; n++) begin
      vld_i = 0; mem_bytes = $urandom;
      @(negedge clk);
      chk(vld_o == 0 && res_o == last, "R9", res_o, last);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule